// File: doc/BRIEF.md
# SPI Register-Access Command Slave

This block is the host-facing port of a CAN-controller-style device. An external master drives an SPI mode-0 link (clock idles low, data sampled on the rising edge, changed on the falling edge, 8-bit words, MSB first). Each transaction is framed by an active-low chip select and starts with a one-byte instruction. The instruction selects one of six kinds of access to a 128-byte register space: plain read, plain write, masked bit-modify, a full register reset, a shortcut that loads a transmit buffer, and a shortcut that reads a receive buffer. Plain and shortcut streams advance the address on every byte for as long as chip select stays low.

The SPI pins are oversampled on the system clock through synchronizer stages, so the serial clock must run well below the system clock. The control register at 0x0F carries a 3-bit mode-request field in bits 7:5. The status register at 0x0E reports the mode that is in effect in its own bits 7:5. A new request becomes visible in status only after a programmable settling delay, which models the time a real controller needs to change its operating mode.

Top module: `spi_regmap_slave`

## Requirements
- R1: After the reset input, the status register (0x0E) reads 0x80: bits 7:5 = 100 (configuration mode) and all other bits 0. The control register (0x0F) reads 0x87: mode request 100 and bits 2:0 = 111. Every other register reads 0x00.
- R2: Instruction 0x03 followed by an address byte returns that register's contents on MISO during the third byte, MSB first, with MISO valid at each rising SCLK edge.
- R3: Instruction 0x02 followed by an address byte and a data byte stores the data byte at that address.
- R4: While chip select stays low, each further data byte of a plain read or write stream moves to the next address, and the address wraps from 0x7F to 0x00.
- R5: Instruction 0x05 followed by address, mask and value bytes writes only the bits set in the mask. All other bits of the register keep their old values, and any further bytes in the frame are ignored.
- R6: Instruction 0xC0 restores every register to its R1 value. It also puts status bits 7:5 back to 100 at once, without the settling delay.
- R7: Instruction 0x40+2n (n = 0..2) writes the following bytes to transmit block n. The first byte lands at address 0x31+0x10*n, and each further byte goes to the next address.
- R8: Instruction 0x90 reads from address 0x61 onward and instruction 0x94 reads from address 0x71 onward. Data starts in the byte right after the instruction and the address advances on each byte.
- R9: Control bits 7:5 are the mode request: 000 normal, 001 sleep, 010 loopback, 011 listen-only, 100 configuration. Status bits 7:5 take the requested code MODE_LAT+1 clock cycles after the control write. A request made while an earlier one is still pending replaces it and restarts the delay. Writes to the status address are ignored.
- R10: Raising chip select before the 8th bit of a byte abandons the transaction, and the unfinished byte writes nothing.
- R11: An instruction byte with any other value makes the rest of the frame inert, so no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the master, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing a transaction |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, registered |

## Verification
The two functions that can meet in one cycle are a fresh write to the mode-request field and the settling counter of an earlier request running out; the mirror lets the fresh write win and restarts the delay. The bench provokes this by writing loopback, then writing listen-only and then sleep back to back, so the second request arrives while the first is still pending. It then reads the status register before and after the delay. A reading of 011 at any time, or of 001 before the restarted delay ends, counts as a fault. Each time a byte completes, the bench also checks that the read-data load and a stream write never share a byte, by comparing the read-back registers after mixed streams.

// File: rtl/spi_regmap_pkg.sv
package spi_regmap_pkg;

  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_BITMOD = 8'h05;
  localparam logic [7:0] OP_RESET  = 8'hC0;

  // shortcut opcode bases and per-buffer opcode step
  localparam int OP_TXLOAD_BASE = 'h40;
  localparam int OP_TXLOAD_STEP = 2;
  localparam int OP_RXREAD_BASE = 'h90;
  localparam int OP_RXREAD_STEP = 4;

  localparam logic [2:0] MODE_NORMAL = 3'b000;
  localparam logic [2:0] MODE_SLEEP  = 3'b001;
  localparam logic [2:0] MODE_LOOP   = 3'b010;
  localparam logic [2:0] MODE_LISTEN = 3'b011;
  localparam logic [2:0] MODE_CONFIG = 3'b100;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_ADDR,
    ST_STREAM_WR,
    ST_STREAM_RD,
    ST_BM_MASK,
    ST_BM_VAL,
    ST_IGNORE
  } cmd_state_e;

  typedef enum logic [1:0] {
    K_READ,
    K_WRITE,
    K_BITMOD
  } acc_kind_e;

endpackage

// File: rtl/spi_byte_port.sv
module spi_byte_port #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              miso,
  output logic              sel,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] sclk_s, cs_s, mosi_s;
  logic                   sclk_prev;
  logic                   sclk_q, mosi_q;
  logic                   rise, fall;
  logic [CNT_W-1:0]       bit_cnt;
  logic [BYTE_W-2:0]      in_sh;
  logic [BYTE_W-1:0]      out_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s    <= '0;
      cs_s      <= '1;
      mosi_s    <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_s    <= {sclk_s[SYNC_STAGES-2:0], sclk};
      cs_s      <= {cs_s[SYNC_STAGES-2:0], cs_n};
      mosi_s    <= {mosi_s[SYNC_STAGES-2:0], mosi};
      sclk_prev <= sclk_s[SYNC_STAGES-1];
    end
  end

  assign sclk_q = sclk_s[SYNC_STAGES-1];
  assign mosi_q = mosi_s[SYNC_STAGES-1];
  assign sel    = ~cs_s[SYNC_STAGES-1];
  assign rise   = sclk_q & ~sclk_prev;
  assign fall   = ~sclk_q & sclk_prev;

  // receive side: a byte only completes on its last rising edge while selected
  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      bit_cnt  <= '0;
      in_sh    <= '0;
      rx_valid <= 1'b0;
      if (rst) rx_byte <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (rise) begin
        in_sh   <= {in_sh[BYTE_W-3:0], mosi_q};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          rx_valid <= 1'b1;
          rx_byte  <= {in_sh, mosi_q};
        end
      end
    end
  end

  // transmit side: the falling edge between bytes (count back at 0) does not shift
  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      out_sh <= '0;
      miso   <= 1'b0;
    end else if (tx_load) begin
      out_sh <= tx_byte;
      miso   <= tx_byte[BYTE_W-1];
    end else if (fall && bit_cnt != '0) begin
      out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
      miso   <= out_sh[BYTE_W-2];
    end
  end

  // R10
  byte_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(sel));

endmodule

// File: rtl/cmd_engine.sv
module cmd_engine
  import spi_regmap_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int BYTE_W     = 8,
  parameter int TX_BUFS    = 3,
  parameter int RX_BUFS    = 2,
  parameter int TX_BASE    = 'h30,
  parameter int RX_BASE    = 'h60,
  parameter int BUF_STRIDE = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] wr_mask,
  output logic              soft_rst
);
  cmd_state_e        state;
  acc_kind_e         kind;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] mask_q;
  logic              load_pend;

  logic              tx_hit, rx_hit;
  logic [ADDR_W-1:0] tx_start, rx_start;

  // shortcut opcode decode, one comparator per buffer
  always_comb begin
    tx_hit   = 1'b0;
    tx_start = '0;
    for (int n = 0; n < TX_BUFS; n++) begin
      if (rx_byte == BYTE_W'(OP_TXLOAD_BASE + OP_TXLOAD_STEP * n)) begin
        tx_hit   = 1'b1;
        tx_start = ADDR_W'(TX_BASE + BUF_STRIDE * n + 1);
      end
    end
  end

  always_comb begin
    rx_hit   = 1'b0;
    rx_start = '0;
    for (int n = 0; n < RX_BUFS; n++) begin
      if (rx_byte == BYTE_W'(OP_RXREAD_BASE + OP_RXREAD_STEP * n)) begin
        rx_hit   = 1'b1;
        rx_start = ADDR_W'(RX_BASE + BUF_STRIDE * n + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      state     <= ST_OPCODE;
      load_pend <= 1'b0;
      wr_en     <= 1'b0;
      soft_rst  <= 1'b0;
      if (rst) begin
        kind    <= K_READ;
        addr    <= '0;
        mask_q  <= '0;
        wr_addr <= '0;
        wr_data <= '0;
        wr_mask <= '0;
      end
    end else begin
      wr_en     <= 1'b0;
      soft_rst  <= 1'b0;
      load_pend <= 1'b0;
      if (rx_valid) begin
        case (state)
          ST_OPCODE: begin
            if (rx_byte == OP_READ) begin
              kind  <= K_READ;
              state <= ST_ADDR;
            end else if (rx_byte == OP_WRITE) begin
              kind  <= K_WRITE;
              state <= ST_ADDR;
            end else if (rx_byte == OP_BITMOD) begin
              kind  <= K_BITMOD;
              state <= ST_ADDR;
            end else if (rx_byte == OP_RESET) begin
              soft_rst <= 1'b1;
              state    <= ST_IGNORE;
            end else if (tx_hit) begin
              addr  <= tx_start;
              state <= ST_STREAM_WR;
            end else if (rx_hit) begin
              addr      <= rx_start;
              load_pend <= 1'b1;
              state     <= ST_STREAM_RD;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_ADDR: begin
            addr <= rx_byte[ADDR_W-1:0];
            case (kind)
              K_READ: begin
                load_pend <= 1'b1;
                state     <= ST_STREAM_RD;
              end
              K_WRITE:  state <= ST_STREAM_WR;
              default:  state <= ST_BM_MASK;
            endcase
          end
          ST_STREAM_WR: begin
            wr_en   <= 1'b1;
            wr_addr <= addr;
            wr_data <= rx_byte;
            wr_mask <= '1;
            addr    <= addr + 1'b1;
          end
          ST_STREAM_RD: begin
            addr      <= addr + 1'b1;
            load_pend <= 1'b1;
          end
          ST_BM_MASK: begin
            mask_q <= rx_byte;
            state  <= ST_BM_VAL;
          end
          ST_BM_VAL: begin
            wr_en   <= 1'b1;
            wr_addr <= addr;
            wr_data <= rx_byte;
            wr_mask <= mask_q;
            state   <= ST_IGNORE;
          end
          default: state <= ST_IGNORE;
        endcase
      end
    end
  end

  assign rd_addr = addr;
  assign tx_load = load_pend;
  assign tx_byte = rd_data;

  // R10
  write_after_full_byte_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rx_valid));

  // R2
  load_only_when_reading_chk: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> (state == ST_STREAM_RD));

endmodule

// File: rtl/mode_mirror.sv
module mode_mirror
  import spi_regmap_pkg::*;
#(
  parameter int MODE_LAT = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst,
  input  logic       req_load,
  input  logic [2:0] req_code,
  output logic [2:0] mode_now
);
  localparam int CNT_W = (MODE_LAT < 1) ? 1 : $clog2(MODE_LAT + 1);

  logic [CNT_W-1:0] cnt;
  logic [2:0]       pend;
  logic             busy;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      mode_now <= MODE_CONFIG;
      pend     <= MODE_CONFIG;
      busy     <= 1'b0;
      cnt      <= '0;
    end else if (req_load) begin
      pend <= req_code;
      cnt  <= CNT_W'(MODE_LAT);
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) begin
        mode_now <= pend;
        busy     <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R9
  idle_mode_stable_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (!busy && !req_load) |=> $stable(mode_now));

  // R9
  mirror_settles_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (busy && cnt == '0 && !req_load) |=> (mode_now == $past(pend)));

  // R6
  reset_forces_config_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (mode_now == MODE_CONFIG));

endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int ADDR_W       = 7,
  parameter int BYTE_W       = 8,
  parameter int STAT_ADDR    = 'h0E,
  parameter int CTRL_ADDR    = 'h0F,
  parameter int CTRL_DEFAULT = 'h87,
  parameter int MODE_LAT     = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] wr_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] merged;
  logic              ctrl_wr;
  logic [2:0]        mode_now;

  assign merged  = (mem[wr_addr] & ~wr_mask) | (wr_data & wr_mask);
  assign ctrl_wr = wr_en && (wr_addr == CTRL_A);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i == CTRL_ADDR) ? BYTE_W'(CTRL_DEFAULT) : '0;
    end else if (wr_en && wr_addr != STAT_A) begin
      mem[wr_addr] <= merged;
    end
  end

  mode_mirror #(.MODE_LAT(MODE_LAT)) u_mirror (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .req_load (ctrl_wr),
    .req_code (merged[BYTE_W-1 -: 3]),
    .mode_now (mode_now)
  );

  assign rd_data = (rd_addr == STAT_A) ? {mode_now, {(BYTE_W-3){1'b0}}} : mem[rd_addr];

endmodule

// File: rtl/spi_regmap_slave.sv
module spi_regmap_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7,
  parameter int TX_BUFS     = 3,
  parameter int RX_BUFS     = 2,
  parameter int TX_BASE     = 'h30,
  parameter int RX_BASE     = 'h60,
  parameter int BUF_STRIDE  = 'h10,
  parameter int STAT_ADDR   = 'h0E,
  parameter int CTRL_ADDR   = 'h0F,
  parameter int MODE_LAT    = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int BYTE_W = 8;

  logic              sel, rx_valid, tx_load, wr_en, soft_rst;
  logic [BYTE_W-1:0] rx_byte, tx_byte, rd_data, wr_data, wr_mask;
  logic [ADDR_W-1:0] rd_addr, wr_addr;

  spi_byte_port #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W)) u_port (
    .clk      (clk),
    .rst      (rst),
    .sclk     (spi_sclk),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .miso     (spi_miso),
    .sel      (sel),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte)
  );

  cmd_engine #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .TX_BUFS(TX_BUFS), .RX_BUFS(RX_BUFS),
    .TX_BASE(TX_BASE), .RX_BASE(RX_BASE), .BUF_STRIDE(BUF_STRIDE)
  ) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_mask  (wr_mask),
    .soft_rst (soft_rst)
  );

  reg_bank #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .STAT_ADDR(STAT_ADDR),
    .CTRL_ADDR(CTRL_ADDR), .CTRL_DEFAULT('h87), .MODE_LAT(MODE_LAT)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_mask  (wr_mask),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

endmodule

// File: tb/spi_regmap_slave_test.sv
module spi_regmap_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;    // system clocks per SCLK half period
  localparam int LAT        = 600;  // mode settling delay under test
  localparam int SETTLE     = 900;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regmap_slave #(.MODE_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  logic [7:0] send_q[$];
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] msk_q[$];
  string      tag_q[$];
  int n_checks = 0, n_fail = 0;
  bit reported = 0;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // driver: shifts send_q out; bytes from index skip on are captured for the monitor
  task automatic spi_txn(input int skip, input int abort_bits);
    logic [7:0] b, r;
    r = 8'h00;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < send_q.size(); i++) begin
      b = send_q[i];
      for (int k = 7; k >= 0; k--) begin
        mosi = b[k];
        wait_clk(HALF);
        sclk = 1'b1;
        r = {r[6:0], miso};
        wait_clk(HALF);
        sclk = 1'b0;
      end
      if (i >= skip) got_q.push_back(r);
    end
    for (int k = 0; k < abort_bits; k++) begin
      mosi = 1'b1;
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(4*HALF);
    send_q.delete();
  endtask

  task automatic expect_byte(input logic [7:0] v, input logic [7:0] m, input string tag);
    exp_q.push_back(v);
    msk_q.push_back(m);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    send_q.push_back(8'h02); send_q.push_back(a); send_q.push_back(d);
    spi_txn(99, 0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    expect_byte(e, 8'hFF, tag);
    send_q.push_back(8'h03); send_q.push_back(a); send_q.push_back(8'h00);
    spi_txn(2, 0);
  endtask

  // monitor: pops captured bytes against the expectation queue
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e, m;
        string t;
        g = got_q.pop_front(); e = exp_q.pop_front();
        m = msk_q.pop_front(); t = tag_q.pop_front();
        n_checks++;
        if ((g & m) !== (e & m)) begin
          n_fail++;
          $display("FAIL %s: got %02h expected %02h (mask %02h)", t, g, e, m);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(10);

    // R1 reset state
    rd(8'h0E, 8'h80, "R1 status");
    expect_byte(8'h07, 8'h17, "R1 control masked");
    send_q.push_back(8'h03); send_q.push_back(8'h0F); send_q.push_back(8'h00);
    spi_txn(2, 0);
    rd(8'h0F, 8'h87, "R1 control full");
    rd(8'h55, 8'h00, "R1 other reg");

    // R2 / R3 plain write then read
    wr(8'h20, 8'hA5);
    rd(8'h20, 8'hA5, "R2 R3 readback");
    wr(8'h21, 8'h3C);
    rd(8'h21, 8'h3C, "R3 second addr");

    // R4 write stream across the wrap, then read stream across the wrap
    send_q = '{8'h02, 8'h7E, 8'h11, 8'h22, 8'h33};
    spi_txn(99, 0);
    expect_byte(8'h11, 8'hFF, "R4 rd 7E");
    expect_byte(8'h22, 8'hFF, "R4 rd 7F");
    expect_byte(8'h33, 8'hFF, "R4 rd 00 wrap");
    send_q = '{8'h03, 8'h7E, 8'h00, 8'h00, 8'h00};
    spi_txn(2, 0);

    // R5 bit modify: (A5 & F0) | (3C & 0F) = AC, trailing byte ignored
    send_q = '{8'h05, 8'h20, 8'h0F, 8'h3C, 8'hFF};
    spi_txn(99, 0);
    rd(8'h20, 8'hAC, "R5 masked merge");
    rd(8'h21, 8'h3C, "R5 neighbour untouched");

    // R7 transmit load shortcuts
    send_q = '{8'h42, 8'hB1, 8'hB2, 8'hB3};
    spi_txn(99, 0);
    expect_byte(8'hB1, 8'hFF, "R7 tx1 41");
    expect_byte(8'hB2, 8'hFF, "R7 tx1 42");
    expect_byte(8'hB3, 8'hFF, "R7 tx1 43");
    send_q = '{8'h03, 8'h41, 8'h00, 8'h00, 8'h00};
    spi_txn(2, 0);
    send_q = '{8'h40, 8'h9A};
    spi_txn(99, 0);
    rd(8'h31, 8'h9A, "R7 tx0 31");
    send_q = '{8'h44, 8'h7D};
    spi_txn(99, 0);
    rd(8'h51, 8'h7D, "R7 tx2 51");

    // R8 receive read shortcuts
    send_q = '{8'h02, 8'h61, 8'hC1, 8'hC2};
    spi_txn(99, 0);
    send_q = '{8'h02, 8'h71, 8'hD1, 8'hD2};
    spi_txn(99, 0);
    expect_byte(8'hC1, 8'hFF, "R8 rx0 61");
    expect_byte(8'hC2, 8'hFF, "R8 rx0 62");
    send_q = '{8'h90, 8'h00, 8'h00};
    spi_txn(1, 0);
    expect_byte(8'hD1, 8'hFF, "R8 rx1 71");
    expect_byte(8'hD2, 8'hFF, "R8 rx1 72");
    send_q = '{8'h94, 8'h00, 8'h00};
    spi_txn(1, 0);

    // R10 aborted data byte leaves the register alone
    wr(8'h30, 8'h55);
    send_q = '{8'h02, 8'h30};
    spi_txn(99, 5);
    rd(8'h30, 8'h55, "R10 partial byte");
    send_q = '{8'h02, 8'h30};
    spi_txn(99, 7);
    rd(8'h30, 8'h55, "R10 seven bits");

    // R11 unknown opcode
    send_q = '{8'h07, 8'h30, 8'h99};
    spi_txn(99, 0);
    rd(8'h30, 8'h55, "R11 inert frame");

    // R9 mode request with settling delay
    wr(8'h0F, 8'h40);
    rd(8'h0E, 8'h80, "R9 before settle");
    wait_clk(SETTLE);
    rd(8'h0E, 8'h40, "R9 after settle loopback");
    wr(8'h0E, 8'hFF);
    rd(8'h0E, 8'h40, "R9 status write ignored");
    // overlapping requests: listen-only replaced by sleep before it settles
    wr(8'h0F, 8'h60);
    wr(8'h0F, 8'h20);
    rd(8'h0E, 8'h40, "R9 restarted delay");
    wait_clk(SETTLE);
    rd(8'h0E, 8'h20, "R9 later request wins");
    // bit modify on the request field only
    send_q = '{8'h05, 8'h0F, 8'hE0, 8'h00};
    spi_txn(99, 0);
    wait_clk(SETTLE);
    rd(8'h0E, 8'h00, "R9 R5 normal via modify");
    rd(8'h0F, 8'h00, "R9 control readback");

    // R6 reset instruction
    send_q = '{8'hC0};
    spi_txn(99, 0);
    rd(8'h0E, 8'h80, "R6 config at once");
    rd(8'h0F, 8'h87, "R6 control default");
    rd(8'h20, 8'h00, "R6 data cleared");

    wait_clk(50);
    if (got_q.size() != 0 || exp_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard: got %0d captured expected %0d pending", got_q.size(), exp_q.size());
    end
    report();
  end

endmodule